// File: doc/BRIEF.md
# Sector ECC Syndrome Checker and Single-Bit Corrector

This block checks one 512-byte sector after a read. It takes the 24-bit ECC word read back from the spare area and the 24-bit ECC word computed over the data just read. It XORs the two words into a syndrome and sorts the result into one of four outcomes:

- the data is clean;
- one data bit is wrong and can be repaired;
- only the ECC bytes themselves took a hit;
- the sector cannot be repaired.

When one data bit is wrong, the block reports the byte index and the bit position of that bit. Each ECC word is made of two 12-bit parity halves, both held inverted. Because of this, a fully erased sector with an all-ones ECC word produces a zero syndrome and reads as clean.

A pulse on `start` captures the two words. One clock later, `done` pulses and the verdict appears on the outputs. The verdict stays on the outputs until the next `start`. While the sector's bytes are replayed through the data port, the block flips the flagged bit in the matching byte and passes every other byte through unchanged. Computing the parity over the data stream is done elsewhere.

Top module: `ecc_hamming_check`

## Requirements
- R1: After reset, `done` is 0, `status` is 0, `err_byte` is 0 and `err_bit` is 0.
- R2: A `start` sampled high at a rising edge makes `done` high for the following cycle. `done` is low after any edge where `start` was low.
- R3: The syndrome is `stored_ecc XOR calc_ecc`. A zero syndrome, including two all-ones (erased) words, gives status 0 (clean).
- R4: If syndrome bits 23:12 XOR syndrome bits 11:0 equal 12'hFFF, the error is a single data bit. In that case the bit position is syndrome bits 14:12 and the byte index is syndrome bits 23:15.
- R5: A single data-bit error whose byte index is below `SECTOR_BYTES` gives status 1 (corrected), with `err_byte` and `err_bit` set to that index and that position.
- R6: A single data-bit error whose byte index is `SECTOR_BYTES` or more gives status 3 (uncorrectable).
- R7: A syndrome with exactly one bit set gives status 2 (ECC-only error).
- R8: Any other nonzero syndrome gives status 3 (uncorrectable).
- R9: When status is not 1, `err_byte` and `err_bit` are 0.
- R10: When status is 1 and `fix_idx` equals `err_byte`, `fix_out` equals `fix_in` XOR (1 << `err_bit`). In every other case, `fix_out` equals `fix_in`.
- R11: The status, byte index and bit position stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the two ECC words and classify them |
| stored_ecc | input | 24 | ECC word read back from the spare area |
| calc_ecc | input | 24 | ECC word computed over the data just read |
| fix_idx | input | 9 | Byte index of the byte presented on `fix_in` |
| fix_in | input | 8 | Sector data byte to be repaired |
| done | output | 1 | One-cycle pulse: the verdict is valid |
| status | output | 2 | 0 clean, 1 corrected, 2 ECC-only, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the flipped bit |
| err_bit | output | 3 | Bit position of the flipped bit |
| fix_out | output | 8 | `fix_in` with the flagged bit repaired |

## Verification
The assertions assume three things about the inputs:
- `start` is a clean, synchronous level.
- The ECC words are stable at the sampling edge.
- `fix_idx` and `fix_in` may change freely, because the repair path has no state.

The stimulus drives every input on the falling edge, so the sampling edge always sees settled values. The syndromes are built by XORing a chosen pattern into a base word, which makes each class (complement pair, single set bit, and other patterns) reachable on purpose. A second instance with a smaller sector exercises the out-of-range byte index, which the default sector size can never produce.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_ECC_ONLY = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_chk_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int BIT_W        = 3,
  parameter int SECTOR_BYTES = 512,
  localparam int ECC_W  = 2 * HALF_W,
  localparam int BYTE_W = HALF_W - BIT_W
) (
  input  logic [ECC_W-1:0]  stored_ecc,
  input  logic [ECC_W-1:0]  calc_ecc,
  output ecc_status_e       cls_status,
  output logic [BYTE_W-1:0] cls_byte,
  output logic [BIT_W-1:0]  cls_bit
);
  logic [ECC_W-1:0]  syn;
  logic [HALF_W-1:0] syn_hi, syn_lo;
  logic              is_pair, is_single, in_range;
  logic [BYTE_W-1:0] pos_byte;
  logic [BIT_W-1:0]  pos_bit;

  always_comb begin
    syn       = stored_ecc ^ calc_ecc;
    syn_hi    = syn[ECC_W-1:HALF_W];
    syn_lo    = syn[HALF_W-1:0];
    is_pair   = ((syn_hi ^ syn_lo) == {HALF_W{1'b1}});
    is_single = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
    pos_bit   = syn_hi[BIT_W-1:0];
    pos_byte  = syn_hi[HALF_W-1:BIT_W];
    in_range  = (32'(pos_byte) < SECTOR_BYTES);

    cls_status = ST_UNCORR;
    cls_byte   = '0;
    cls_bit    = '0;
    if (syn == '0) begin
      cls_status = ST_CLEAN;
    end else if (is_pair) begin
      if (in_range) begin
        cls_status = ST_FIXED;
        cls_byte   = pos_byte;
        cls_bit    = pos_bit;
      end
    end else if (is_single) begin
      cls_status = ST_ECC_ONLY;
    end
  end
endmodule

// File: rtl/ecc_result_reg.sv
module ecc_result_reg
  import ecc_chk_pkg::*;
#(
  parameter int BYTE_W       = 9,
  parameter int BIT_W        = 3,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n_sync,
  input  logic              start,
  input  ecc_status_e       cls_status,
  input  logic [BYTE_W-1:0] cls_byte,
  input  logic [BIT_W-1:0]  cls_bit,
  output logic              done,
  output ecc_status_e       res_status,
  output logic [BYTE_W-1:0] res_byte,
  output logic [BIT_W-1:0]  res_bit
);
  logic              done_d;
  ecc_status_e       status_d;
  logic [BYTE_W-1:0] byte_d;
  logic [BIT_W-1:0]  bit_d;

  always_comb begin
    done_d   = start;
    status_d = res_status;
    byte_d   = res_byte;
    bit_d    = res_bit;
    if (start) begin
      status_d = cls_status;
      byte_d   = cls_byte;
      bit_d    = cls_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      done       <= 1'b0;
      res_status <= ST_CLEAN;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      done       <= done_d;
      res_status <= status_d;
      res_byte   <= byte_d;
      res_bit    <= bit_d;
    end
  end

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start |=> done);
  p_no_done_without_start_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !start |=> !done);
  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !start |=> ($stable(res_status) && $stable(res_byte) && $stable(res_bit)));
  p_fixed_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (res_status == ST_FIXED) |-> (32'(res_byte) < SECTOR_BYTES));
  p_pos_zero_unless_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (res_status != ST_FIXED) |-> (res_byte == '0 && res_bit == '0));
endmodule

// File: rtl/ecc_byte_fix.sv
module ecc_byte_fix
  import ecc_chk_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int BIT_W  = 3,
  localparam int DATA_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rst_n_sync,
  input  ecc_status_e       res_status,
  input  logic [BYTE_W-1:0] res_byte,
  input  logic [BIT_W-1:0]  res_bit,
  input  logic [BYTE_W-1:0] fix_idx,
  input  logic [DATA_W-1:0] fix_in,
  output logic [DATA_W-1:0] fix_out
);
  logic [DATA_W-1:0] flip_mask;
  logic              hit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign flip_mask[g] = (res_bit == BIT_W'(g));
  end

  always_comb begin
    hit     = (res_status == ST_FIXED) && (fix_idx == res_byte);
    fix_out = hit ? (fix_in ^ flip_mask) : fix_in;
  end

  p_at_most_one_flip_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $countones(fix_out ^ fix_in) <= 1);
  p_pass_unless_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (res_status != ST_FIXED) |-> (fix_out == fix_in));
endmodule

// File: rtl/ecc_hamming_check.sv
module ecc_hamming_check
  import ecc_chk_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int BIT_W        = 3,
  parameter int SECTOR_BYTES = 512,
  localparam int ECC_W  = 2 * HALF_W,
  localparam int BYTE_W = HALF_W - BIT_W,
  localparam int DATA_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ECC_W-1:0]  stored_ecc,
  input  logic [ECC_W-1:0]  calc_ecc,
  input  logic [BYTE_W-1:0] fix_idx,
  input  logic [DATA_W-1:0] fix_in,
  output logic              done,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit,
  output logic [DATA_W-1:0] fix_out
);
  logic              rst_n_sync;
  ecc_status_e       cls_status, res_status;
  logic [BYTE_W-1:0] cls_byte;
  logic [BIT_W-1:0]  cls_bit;

  ecc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  ecc_classify #(.HALF_W(HALF_W), .BIT_W(BIT_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .stored_ecc(stored_ecc), .calc_ecc(calc_ecc),
    .cls_status(cls_status), .cls_byte(cls_byte), .cls_bit(cls_bit)
  );

  ecc_result_reg #(.BYTE_W(BYTE_W), .BIT_W(BIT_W), .SECTOR_BYTES(SECTOR_BYTES)) u_res (
    .clk(clk), .rst_n_sync(rst_n_sync), .start(start),
    .cls_status(cls_status), .cls_byte(cls_byte), .cls_bit(cls_bit),
    .done(done), .res_status(res_status), .res_byte(err_byte), .res_bit(err_bit)
  );

  ecc_byte_fix #(.BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_fix (
    .clk(clk), .rst_n_sync(rst_n_sync),
    .res_status(res_status), .res_byte(err_byte), .res_bit(err_bit),
    .fix_idx(fix_idx), .fix_in(fix_in), .fix_out(fix_out)
  );

  assign status = res_status;

  p_clean_iff_equal_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start |=> ((status == 2'd0) == ($past(stored_ecc) == $past(calc_ecc))));
  p_single_bit_ecc_only_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && $countones(stored_ecc ^ calc_ecc) == 1) |=> (status == 2'd2));
  p_fixed_has_pair_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && $countones(stored_ecc ^ calc_ecc) < HALF_W) |=> (status != 2'd1));
endmodule

// File: tb/ecc_hamming_check_tb.sv
module ecc_hamming_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic [8:0]  fix_idx = '0;
  logic [7:0]  fix_in = '0;
  logic        done, done_s;
  logic [1:0]  status, status_s;
  logic [8:0]  err_byte, err_byte_s;
  logic [2:0]  err_bit, err_bit_s;
  logic [7:0]  fix_out, fix_out_s;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_hamming_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_ecc(stored_ecc), .calc_ecc(calc_ecc),
    .fix_idx(fix_idx), .fix_in(fix_in), .done(done), .status(status),
    .err_byte(err_byte), .err_bit(err_bit), .fix_out(fix_out)
  );

  ecc_hamming_check #(.SECTOR_BYTES(256)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_ecc(stored_ecc), .calc_ecc(calc_ecc),
    .fix_idx(fix_idx), .fix_in(fix_in), .done(done_s), .status(status_s),
    .err_byte(err_byte_s), .err_bit(err_bit_s), .fix_out(fix_out_s)
  );

  // columns: base word, syndrome, expected status, byte, bit
  localparam int NV = 11;
  localparam logic [23:0] V_BASE [NV] = '{24'hFFFFFF, 24'h123456, 24'hABCDEF, 24'h5A5A5A,
    24'h0F0F0F, 24'h000000, 24'h777777, 24'h3C3C3C, 24'h000000, 24'hFFFFFF, 24'h246801};
  localparam logic [23:0] V_SYN [NV] = '{24'h000000, 24'h000000, 24'h000FFF, 24'hFFF000,
    24'h9556AA, 24'h000001, 24'h800000, 24'h000800, 24'h000003, 24'hFFFFFF, 24'h955AAA};
  localparam logic [1:0] V_ST [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2,
    2'd3, 2'd3, 2'd3};
  localparam logic [8:0] V_BY [NV] = '{9'd0, 9'd0, 9'd0, 9'd511, 9'd298, 9'd0, 9'd0, 9'd0,
    9'd0, 9'd0, 9'd0};
  localparam logic [2:0] V_BI [NV] = '{3'd0, 3'd0, 3'd0, 3'd7, 3'd5, 3'd0, 3'd0, 3'd0,
    3'd0, 3'd0, 3'd0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [23:0] base, input logic [23:0] syn);
    @(negedge clk);
    calc_ecc   = base;
    stored_ecc = base ^ syn;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 status", status, 0);
    check("R1 err_byte", err_byte, 0);
    check("R1 err_bit", err_bit, 0);

    for (int i = 0; i < NV; i++) begin
      run_one(V_BASE[i], V_SYN[i]);
      check("R2 done pulse", done, 1);
      check("R3 R5 R7 R8 status", status, V_ST[i]);
      check("R4 R5 R9 err_byte", err_byte, V_BY[i]);
      check("R4 R5 R9 err_bit", err_bit, V_BI[i]);
      @(negedge clk);
      check("R2 done low", done, 0);
      check("R11 status held", status, V_ST[i]);
    end

    // R10 repair path after a corrected error at byte 298 bit 5
    run_one(24'h0F0F0F, 24'h9556AA);
    fix_idx = 9'd298; fix_in = 8'h00; #1;
    check("R10 flip at index", fix_out, 8'h20);
    fix_idx = 9'd298; fix_in = 8'hFF; #1;
    check("R10 flip at index ones", fix_out, 8'hDF);
    fix_idx = 9'd297; fix_in = 8'h5C; #1;
    check("R10 other index passes", fix_out, 8'h5C);
    // R11 held across idle cycles with changing inputs
    stored_ecc = 24'h000001; calc_ecc = 24'h0;
    repeat (3) @(negedge clk);
    check("R11 hold after idle", status, 1);
    check("R11 byte held", err_byte, 298);
    // R10 ECC-only verdict leaves data untouched
    run_one(24'h000000, 24'h000001);
    fix_idx = 9'd0; fix_in = 8'hAB; #1;
    check("R10 no flip when not corrected", fix_out, 8'hAB);

    // R6 byte index 300 beyond a 256-byte sector: syndrome hi 0x962 lo 0x69D
    run_one(24'h111111, 24'h96269D);
    check("R6 small sector out of range", status_s, 3);
    check("R9 small sector byte zero", err_byte_s, 0);
    check("R5 large sector corrects 300", status, 1);
    check("R5 large sector byte", err_byte, 300);
    check("R5 large sector bit", err_bit, 2);
    // R5 byte 255 bit 1 inside the small sector: hi 0x7F9 lo 0x806
    run_one(24'h222222, 24'h7F9806);
    check("R5 small sector in range", status_s, 1);
    check("R5 small sector byte", err_byte_s, 255);
    check("R5 small sector bit", err_bit_s, 1);

    // R2 back-to-back starts keep done high
    @(negedge clk);
    calc_ecc = 24'h0; stored_ecc = 24'h0; start = 1'b1;
    @(negedge clk);
    check("R2 first of pair", done, 1);
    @(negedge clk);
    start = 1'b0;
    check("R2 second of pair", done, 1);
    @(negedge clk);
    check("R2 pair ends", done, 0);

    // R1 reset mid-run clears results
    run_one(24'h0F0F0F, 24'h9556AA);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 status after reset", status, 0);
    check("R1 byte after reset", err_byte, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule